// File: doc/BRIEF.md
# Compare-and-branch fusion detector

This block sits behind an instruction decoder and watches the stream of decoded instructions one at a time. Each instruction arrives in a simplified record: an operation class, an operand-kind code, an indexed-addressing flag, a condition code and a data word (operands for an arithmetic instruction, target for a branch). When a flag-producing instruction is directly followed by a conditional branch that it may legally pair with, the two leave as one compare-and-branch micro-op. Every other instruction passes through unchanged and in order.

A flag producer that could pair is parked in a one-entry holding slot until the next instruction shows up. That instruction either completes a pair or causes the parked one to be released alone. A flush input discards the parked instruction. Two counters track retired instructions and issued micro-ops; a fused micro-op counts as two instructions but one micro-op. Both sides use valid/ready handshakes.

Top module: `fuse_detect`

## Requirements
- R1: After reset no instruction is held, `out_valid` is 0 and both counters read 0.
- R2: Class codes are 0 other, 1 CMP, 2 TEST, 3 ADD, 4 SUB, 5 INC, 6 DEC, 7 conditional branch. A CMP or TEST directly followed by a branch leaves as one micro-op with `out_fused`=1, the producer's class, operand kinds, index flag and data, the branch's condition in `out_cond` and the branch's data in `out_tgt`; for any unfused output `out_fused`=0 and `out_tgt`=0.
- R3: ADD or SUB fuse with a branch only for conditions 2,3,4,5,6,7,12,13,14,15; INC or DEC only for conditions 4,5,12,13,14,15. Any other condition releases the producer and then the branch as two plain outputs.
- R4: Any instruction between the producer and the branch prevents fusion; all three leave separately in input order.
- R5: Operand kinds are 0 reg-reg, 1 reg-imm, 2 mem-reg, 3 mem-imm. A producer with kind 3 never fuses and passes straight through without being held; kind 2 may fuse.
- R6: The index flag `in_idx` has no effect on the fusion decision and is carried to `out_idx`.
- R7: A producer that may fuse produces no output until the next instruction is presented; if that instruction is not a fusing branch, the producer is emitted alone first.
- R8: On each output handshake `insn_cnt` rises by 2 for a fused micro-op and by 1 otherwise, and `uop_cnt` rises by 1; without a handshake neither changes.
- R9: While `flush` is high no output is offered, no input is accepted, and any held instruction is discarded.
- R10: While `out_ready` is low nothing is consumed and the offered output stays the same for the same input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Discard held instruction |
| in_valid | input | 1 | Input record valid |
| in_ready | output | 1 | Input record accepted |
| in_cls | input | 3 | Operation class |
| in_opk | input | 2 | Operand kinds |
| in_idx | input | 1 | Indexed addressing flag |
| in_cond | input | 4 | Condition code |
| in_data | input | DW | Operands or branch target |
| out_valid | output | 1 | Output micro-op valid |
| out_ready | input | 1 | Consumer ready |
| out_fused | output | 1 | Micro-op is a fused pair |
| out_cls | output | 3 | Class of the (first) instruction |
| out_opk | output | 2 | Operand kinds |
| out_idx | output | 1 | Indexed addressing flag |
| out_cond | output | 4 | Condition code (branch's when fused) |
| out_data | output | DW | Operands of the (first) instruction |
| out_tgt | output | DW | Branch target when fused, else 0 |
| insn_cnt | output | CW | Retired instruction count |
| uop_cnt | output | CW | Issued micro-op count |

## Verification
Directed pairs cover each producer class against permitted and refused conditions, separating a correct condition table from one that is too loose or too strict. Mem-imm against mem-reg compares and indexed operands separate the operand-kind rule from the index flag, and an inserted instruction or a flush between producer and branch separates true adjacency from simply remembering the last producer. A long random run with stalls on both sides and occasional flushes then compares every output and both counters with a queue-based model on every cycle.

// File: rtl/fuse_detect.sv
module fuse_detect #(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_cls,
  input  logic [1:0]    in_opk,
  input  logic          in_idx,
  input  logic [3:0]    in_cond,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_fused,
  output logic [2:0]    out_cls,
  output logic [1:0]    out_opk,
  output logic          out_idx,
  output logic [3:0]    out_cond,
  output logic [DW-1:0] out_data,
  output logic [DW-1:0] out_tgt,
  output logic [CW-1:0] insn_cnt,
  output logic [CW-1:0] uop_cnt
);
  localparam logic [2:0] C_CMP = 3'd1, C_ADD = 3'd3, C_SUB = 3'd4,
                         C_INC = 3'd5, C_DEC = 3'd6, C_JCC = 3'd7;
  localparam logic [1:0] K_MIMM = 2'd3;

  function automatic logic cond_ok(input logic [2:0] c, input logic [2:0] cc_hi);
    case (c)
      C_ADD, C_SUB: cond_ok = cc_hi inside {3'd1, 3'd2, 3'd3, 3'd6, 3'd7};
      C_INC, C_DEC: cond_ok = cc_hi inside {3'd2, 3'd6, 3'd7};
      default:      cond_ok = 1'b1;
    endcase
  endfunction

  logic          hv;
  logic [2:0]    h_cls;
  logic [1:0]    h_opk;
  logic          h_idx;
  logic [3:0]    h_cond;
  logic [DW-1:0] h_data;

  wire in_setter = (in_cls >= C_CMP) && (in_cls <= C_DEC) && (in_opk != K_MIMM);
  wire pair      = hv && in_valid && (in_cls == C_JCC) && cond_ok(h_cls, in_cond[3:1]);
  wire fire      = out_valid && out_ready;
  wire take      = in_valid && in_ready;

  always_comb begin
    out_valid = 1'b0;
    in_ready  = 1'b0;
    out_fused = 1'b0;
    out_cls   = in_cls;
    out_opk   = in_opk;
    out_idx   = in_idx;
    out_cond  = in_cond;
    out_data  = in_data;
    out_tgt   = '0;
    if (flush) begin
      in_ready = 1'b0;
    end else if (hv) begin
      out_valid = in_valid;
      out_cls   = h_cls;
      out_opk   = h_opk;
      out_idx   = h_idx;
      out_cond  = h_cond;
      out_data  = h_data;
      in_ready  = out_ready && (pair || in_setter);
      if (pair) begin
        out_fused = 1'b1;
        out_cond  = in_cond;
        out_tgt   = in_data;
      end
    end else if (in_setter) begin
      in_ready = 1'b1;
    end else begin
      out_valid = in_valid;
      in_ready  = out_ready;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      hv <= 1'b0;
    end else if (take && in_setter) begin
      hv     <= 1'b1;
      h_cls  <= in_cls;
      h_opk  <= in_opk;
      h_idx  <= in_idx;
      h_cond <= in_cond;
      h_data <= in_data;
    end else if (fire) begin
      hv <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      insn_cnt <= '0;
      uop_cnt  <= '0;
    end else if (fire) begin
      insn_cnt <= insn_cnt + (out_fused ? CW'(2) : CW'(1));
      uop_cnt  <= uop_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/fuse_detect_chk.sv
module fuse_detect_chk #(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_fused,
  input logic [2:0]    out_cls,
  input logic [1:0]    out_opk,
  input logic [3:0]    out_cond,
  input logic [DW-1:0] out_tgt,
  input logic [CW-1:0] insn_cnt,
  input logic [CW-1:0] uop_cnt
);
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!out_valid && !in_ready)); // R9
  AST_INSN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> insn_cnt == $past(insn_cnt) + ($past(out_fused) ? CW'(2) : CW'(1))); // R8
  AST_UOP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> uop_cnt == $past(uop_cnt) + CW'(1)); // R8
  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_ready) |=> ($stable(insn_cnt) && $stable(uop_cnt))); // R8
  AST_NO_MEMIMM_FUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fused) |-> out_opk != 2'd3); // R5
  AST_UNFUSED_NO_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_fused) |-> out_tgt == '0); // R2
  AST_FUSED_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fused) |-> (out_cls >= 3'd1 && out_cls <= 3'd6)); // R2
  AST_INCDEC_COND: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fused && (out_cls == 3'd5 || out_cls == 3'd6))
      |-> out_cond inside {4'd4, 4'd5, 4'd12, 4'd13, 4'd14, 4'd15}); // R3
endmodule

bind fuse_detect fuse_detect_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_fused(out_fused),
  .out_cls(out_cls), .out_opk(out_opk), .out_cond(out_cond), .out_tgt(out_tgt),
  .insn_cnt(insn_cnt), .uop_cnt(uop_cnt)
);

// File: tb/sim_fuse_detect.sv
`timescale 1ns/1ps
module sim_fuse_detect;
  typedef struct packed {
    logic [2:0]  cls;
    logic [1:0]  opk;
    logic        idx;
    logic [3:0]  cond;
    logic [15:0] data;
  } ins_t;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic in_valid = 1'b0, in_ready, in_idx = 1'b0, out_ready = 1'b0;
  logic [2:0] in_cls = '0;
  logic [1:0] in_opk = '0;
  logic [3:0] in_cond = '0;
  logic [15:0] in_data = '0;
  logic out_valid, out_fused, out_idx;
  logic [2:0] out_cls;
  logic [1:0] out_opk;
  logic [3:0] out_cond;
  logic [15:0] out_data, out_tgt, insn_cnt, uop_cnt;

  always #2.5 clk = ~clk;

  fuse_detect u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_opk(in_opk), .in_idx(in_idx), .in_cond(in_cond), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_fused(out_fused), .out_cls(out_cls),
    .out_opk(out_opk), .out_idx(out_idx), .out_cond(out_cond), .out_data(out_data),
    .out_tgt(out_tgt), .insn_cnt(insn_cnt), .uop_cnt(uop_cnt)
  );

  int compared = 0, mismatched = 0;
  string phase = "R1";
  ins_t held[$];
  ins_t cur;
  bit cur_v = 0, ordy = 1, fl = 0, acc = 0;
  logic [15:0] m_insn = 0, m_uop = 0;

  function automatic bit producer(ins_t i);
    return (i.cls >= 1 && i.cls <= 6) && i.opk != 2'd3;
  endfunction

  function automatic bit may_pair(ins_t p, ins_t b);
    if (b.cls != 3'd7) return 0;
    if (p.cls == 3'd3 || p.cls == 3'd4)
      return b.cond inside {2, 3, 4, 5, 6, 7, 12, 13, 14, 15};
    if (p.cls == 3'd5 || p.cls == 3'd6)
      return b.cond inside {4, 5, 12, 13, 14, 15};
    return 1;
  endfunction

  task automatic step();
    bit e_ov, e_ir, e_f, bad;
    ins_t e_o;
    logic [15:0] e_t;
    @(negedge clk);
    in_valid = cur_v; in_cls = cur.cls; in_opk = cur.opk; in_idx = cur.idx;
    in_cond = cur.cond; in_data = cur.data; out_ready = ordy; flush = fl;
    #1;
    e_ov = 0; e_ir = 0; e_f = 0; e_o = cur; e_t = 0;
    if (fl) begin
      e_ir = 0;
    end else if (held.size() > 0) begin
      e_o = held[0];
      e_ov = cur_v;
      e_f = cur_v && may_pair(held[0], cur);
      if (e_f) begin e_o.cond = cur.cond; e_t = cur.data; end
      e_ir = ordy && (e_f || producer(cur));
    end else if (producer(cur)) begin
      e_ir = 1;
    end else begin
      e_ov = cur_v; e_ir = ordy;
    end
    compared++;
    bad = (out_valid !== e_ov) || (insn_cnt !== m_insn) || (uop_cnt !== m_uop);
    if (cur_v && in_ready !== e_ir) bad = 1;
    if (e_ov && (out_fused !== e_f || out_cls !== e_o.cls || out_opk !== e_o.opk ||
                 out_idx !== e_o.idx || out_cond !== e_o.cond || out_data !== e_o.data ||
                 out_tgt !== e_t)) bad = 1;
    if (bad) begin
      mismatched++;
      $display("FAIL %s: got v=%0b rdy=%0b f=%0b cls=%0d opk=%0d idx=%0b cc=%0d d=%h t=%h cnt=%0d/%0d; expected v=%0b rdy=%0b f=%0b cls=%0d opk=%0d idx=%0b cc=%0d d=%h t=%h cnt=%0d/%0d",
               phase, out_valid, in_ready, out_fused, out_cls, out_opk, out_idx, out_cond, out_data,
               out_tgt, insn_cnt, uop_cnt, e_ov, e_ir, e_f, e_o.cls, e_o.opk, e_o.idx, e_o.cond,
               e_o.data, e_t, m_insn, m_uop);
    end
    acc = cur_v && e_ir;
    if (fl) begin
      held.delete();
    end else begin
      if (e_ov && ordy) begin
        m_insn += e_f ? 16'd2 : 16'd1;
        m_uop  += 16'd1;
        if (held.size() > 0) void'(held.pop_front());
      end
      if (acc && producer(cur)) held.push_back(cur);
    end
  endtask

  task automatic send(input int c, input int k, input int x, input int cc, input int d);
    cur = '{cls: 3'(c), opk: 2'(k), idx: 1'(x), cond: 4'(cc), data: 16'(d)};
    cur_v = 1; ordy = 1; fl = 0;
    do step(); while (!acc);
    cur_v = 0;
  endtask

  task automatic idle(input int n);
    cur_v = 0; fl = 0;
    repeat (n) step();
  endtask

  task automatic do_flush();
    cur_v = 0; fl = 1; step(); fl = 0;
  endtask

  initial begin
    #1000000;
    mismatched++;
    $display("FAIL watchdog: got no end, expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    cur = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    phase = "R1 reset state";       idle(2);
    phase = "R2 cmp/test pairs";
    send(1, 0, 0, 9, 16'h1111);  send(7, 0, 0, 9, 16'hA0A0);   idle(1);
    send(2, 2, 0, 1, 16'h2222);  send(7, 0, 0, 0, 16'hB0B0);   idle(1);
    phase = "R3 add/sub/inc/dec conditions";
    send(3, 1, 0, 0, 16'h3333);  send(7, 0, 0, 4, 16'hC0C0);   idle(1);
    send(4, 0, 0, 0, 16'h4444);  send(7, 0, 0, 8, 16'hC1C1);   idle(1);
    send(5, 0, 0, 0, 16'h5555);  send(7, 0, 0, 2, 16'hC2C2);   idle(1);
    send(6, 0, 0, 0, 16'h6666);  send(7, 0, 0, 13, 16'hC3C3);  idle(1);
    send(3, 0, 0, 0, 16'h3434);  send(7, 0, 0, 1, 16'hC4C4);   idle(1);
    phase = "R4 adjacency";
    send(1, 0, 0, 0, 16'h7777);  send(0, 0, 0, 0, 16'h0707);  send(7, 0, 0, 5, 16'hD0D0); idle(1);
    phase = "R5 mem-imm compare";
    send(1, 3, 0, 0, 16'h8888);  send(7, 0, 0, 5, 16'hE0E0);   idle(1);
    send(1, 2, 0, 0, 16'h8989);  send(7, 0, 0, 5, 16'hE1E1);   idle(1);
    phase = "R6 indexed operand";
    send(1, 2, 1, 0, 16'h9999);  send(7, 0, 0, 3, 16'hF0F0);   idle(1);
    phase = "R7 hold and release";
    send(1, 0, 0, 0, 16'hAAAA);  idle(4);  send(2, 0, 0, 0, 16'hABAB);
    send(7, 0, 0, 6, 16'hF1F1);  idle(1);
    phase = "R9 flush";
    send(1, 0, 0, 0, 16'hBBBB);  do_flush();  send(7, 0, 0, 6, 16'hF2F2); idle(2);
    phase = "R10 backpressure";
    cur = '{cls: 3'd1, opk: 2'd0, idx: 1'b0, cond: 4'd0, data: 16'hCCCC};
    cur_v = 1; ordy = 0; step();
    cur = '{cls: 3'd7, opk: 2'd0, idx: 1'b0, cond: 4'd7, data: 16'hCDCD};
    repeat (3) step();
    ordy = 1; do step(); while (!acc);
    idle(1);
    phase = "R8 random stream with counters";
    cur_v = 0;
    for (int n = 0; n < 4000; n++) begin
      if (!cur_v || acc) begin
        cur_v = ($urandom % 4) != 0;
        cur.cls  = ($urandom % 10 < 4) ? 3'd7 : 3'($urandom % 7);
        cur.opk  = 2'($urandom);
        cur.idx  = 1'($urandom);
        cur.cond = 4'($urandom);
        cur.data = 16'($urandom);
      end
      ordy = ($urandom % 4) != 0;
      fl = ($urandom % 50) == 0;
      step();
    end
    fl = 0; idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule